// File: doc/BRIEF.md
# Speculative Store Queue with Age-Ordered Forwarding

This block keeps the stores of an out-of-order core that have been dispatched but are not yet in memory. Stores take slots in program order at dispatch and receive their address and data when they execute. They are marked retired one at a time, oldest first. Retired stores leave from the oldest end through a memory write port with a ready handshake. Until a store retires it is speculative and never reaches the write port.

Age is kept with head, retire and tail pointers that carry one extra wrap bit above the slot index. A load takes a snapshot of the tail pointer when it dispatches and presents it with its address. Every store between the head and that snapshot is older than the load. The lookup runs alongside the cache access. It returns the data of the youngest older store with the same address, or asks the load to wait while an older store has no address yet. On a misprediction the recovery logic presents the tail snapshot of the mispredicted instruction. Every store at or beyond that point is dropped.

Top module: `spec_store_queue`

## Requirements
- R1: With `alloc_req` high, `full` low and `flush_valid` low, the slot shown on `alloc_ptr` is taken and `alloc_ptr` advances by one on the next edge. `full` is high exactly when DEPTH slots are held, and then an allocation request has no effect.
- R2: An execute write stores `ex_addr` and `ex_data` in slot `ex_idx`. From the next cycle that store can forward to loads and leave for memory.
- R3: Each `ret_valid` pulse retires the oldest unretired store. `cm_valid` is high exactly when the head store is retired.
- R4: `cm_addr` and `cm_data` show the head store. It leaves on `cm_valid && cm_ready`, so stores reach memory one at a time in allocation order. An allocation and a commit in the same cycle both take effect.
- R5: With `flush_valid` high, `alloc_ptr` becomes `flush_tail` on the next edge and every store from `flush_tail` onward is removed. A flush wins over an allocation in the same cycle. A `flush_tail` equal to the retire pointer removes every speculative store.
- R6: A store is older than a load when its position lies from the head up to, but not including, `ld_age`. Pointers are DEPTH-modulo indices in the low bits plus a wrap bit on top. When a lookup has at least one older store with a matching address and no wait (R7), `ld_hit` is 1 and `ld_data` is the data of the youngest such store.
- R7: If any older store still has no address, `ld_wait` is 1 and `ld_hit` is 0.
- R8: With no older matching store and no wait, `ld_hit` and `ld_wait` are both 0 and the load uses cache data.
- R9: After reset the queue is empty, with `full`=0, `cm_valid`=0, `alloc_ptr`=0 and no hit or wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Dispatch asks for a store slot |
| full | output | 1 | All slots held |
| alloc_ptr | output | IW+1 | Tail pointer: slot for the next store, with wrap bit |
| ex_valid | input | 1 | Execute write strobe |
| ex_idx | input | IW | Slot being written |
| ex_addr | input | AW | Store address |
| ex_data | input | DW | Store data |
| ret_valid | input | 1 | Retire the oldest unretired store |
| flush_valid | input | 1 | Misprediction recovery |
| flush_tail | input | IW+1 | Tail snapshot of the mispredicted instruction |
| ld_valid | input | 1 | Load lookup strobe |
| ld_addr | input | AW | Load address |
| ld_age | input | IW+1 | Tail snapshot taken at load dispatch |
| ld_hit | output | 1 | Forwarded data valid |
| ld_wait | output | 1 | An older store has no address yet |
| ld_data | output | DW | Forwarded data |
| cm_valid | output | 1 | Retired head store offered to memory |
| cm_ready | input | 1 | Memory accepts the head store |
| cm_addr | output | AW | Address of the head store |
| cm_data | output | DW | Data of the head store |

## Verification
The assertions rely on the caller keeping the pointers in order. A retire pulse only comes while an executed, unretired store exists. `flush_tail` lies between the post-retire pointer and the tail. `ld_age` lies between head and tail. Execute writes only target live, unretired slots that have not been written yet. The stimulus picks each of these values from the range allowed by the reference model's current pointers. Addresses come from eight values, so several older stores often share an address and the youngest-older choice is exercised. A phase with the write port held off fills the queue so that the full and wrap cases occur.

// File: rtl/spec_store_queue.sv
module spec_store_queue #(
  parameter int DEPTH = 32,
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  output logic          full,
  output logic [PW-1:0] alloc_ptr,
  input  logic          ex_valid,
  input  logic [IW-1:0] ex_idx,
  input  logic [AW-1:0] ex_addr,
  input  logic [DW-1:0] ex_data,
  input  logic          ret_valid,
  input  logic          flush_valid,
  input  logic [PW-1:0] flush_tail,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [PW-1:0] ld_age,
  output logic          ld_hit,
  output logic          ld_wait,
  output logic [DW-1:0] ld_data,
  output logic          cm_valid,
  input  logic          cm_ready,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data
);

  logic [PW-1:0]    head, ret, tail;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] known;

  wire [PW-1:0] used     = tail - head;
  wire          alloc_go = alloc_req && !full && !flush_valid;
  wire          commit   = cm_valid && cm_ready;

  assign full      = used == PW'(DEPTH);
  assign alloc_ptr = tail;
  assign cm_valid  = head != ret;
  assign cm_addr   = addr_q[head[IW-1:0]];
  assign cm_data   = data_q[head[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      ret   <= '0;
      tail  <= '0;
      known <= '0;
    end else begin
      if (commit) head <= head + PW'(1);
      if (ret_valid) ret <= ret + PW'(1);
      if (flush_valid) tail <= flush_tail;
      else if (alloc_go) tail <= tail + PW'(1);
      if (ex_valid) known[ex_idx] <= 1'b1;
      if (alloc_go) known[tail[IW-1:0]] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ex_valid) begin
      addr_q[ex_idx] <= ex_addr;
      data_q[ex_idx] <= ex_data;
    end
  end

  logic          fwd_hit, fwd_wait;
  logic [IW-1:0] fwd_sel;
  wire  [PW-1:0] span = ld_age - head;

  always_comb begin
    fwd_hit  = 1'b0;
    fwd_wait = 1'b0;
    fwd_sel  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IW-1:0] slot;
      slot = head[IW-1:0] + IW'(k);
      if (PW'(k) < span) begin
        if (!known[slot]) fwd_wait = 1'b1;
        else if (addr_q[slot] == ld_addr) begin
          fwd_hit = 1'b1;
          fwd_sel = slot;
        end
      end
    end
  end

  assign ld_wait = ld_valid && fwd_wait;
  assign ld_hit  = ld_valid && fwd_hit && !fwd_wait;
  assign ld_data = ld_hit ? data_q[fwd_sel] : '0;

  a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (tail - head) <= PW'(DEPTH));
  a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    full && !flush_valid |=> alloc_ptr == $past(alloc_ptr));
  a_r1_alloc_step: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req && !full && !flush_valid |=> alloc_ptr == $past(alloc_ptr) + PW'(1));
  a_r5_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> alloc_ptr == $past(flush_tail));
  a_r3_commit_known: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> known[head[IW-1:0]]);
  a_r4_commit_step: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && cm_ready |=> head == $past(head) + PW'(1));
  a_r7_hit_wait_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_wait));

endmodule

// File: tb/spec_store_queue_test.sv
module spec_store_queue_test;
  localparam int DEPTH = 32;
  localparam int IW = 5;
  localparam int PW = 6;
  localparam int RING = 4096;

  logic clk = 0, rst_n = 0;
  logic alloc_req = 0, ex_valid = 0, ret_valid = 0, flush_valid = 0, ld_valid = 0, cm_ready = 0;
  logic [IW-1:0] ex_idx = '0;
  logic [31:0] ex_addr = '0, ex_data = '0, ld_addr = '0;
  logic [PW-1:0] flush_tail = '0, ld_age = '0;
  logic full, ld_hit, ld_wait, cm_valid;
  logic [PW-1:0] alloc_ptr;
  logic [31:0] ld_data, cm_addr, cm_data;

  spec_store_queue #(.DEPTH(DEPTH), .AW(32), .DW(32)) uut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: sequence numbers, stores kept in a ring of records
  int m_head = 0, m_ret = 0, m_tail = 0;
  bit m_av [RING];
  logic [31:0] m_addr [RING];
  logic [31:0] m_data [RING];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p_alloc, p_flush, p_ready;
    bit was_flush;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ld_valid = 1;
    ld_age = '0;
    ld_addr = 32'h0;
    #1;
    chk("R9 full", full, 0);
    chk("R9 cm_valid", cm_valid, 0);
    chk("R9 alloc_ptr", alloc_ptr, 0);
    chk("R9 ld_hit", ld_hit, 0);
    chk("R9 ld_wait", ld_wait, 0);
    was_flush = 0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      bit a, rv, ex, fl, e_full, e_cmv, e_hit, e_wait;
      int s, ft, age, lo;
      logic [31:0] e_ld;
      @(negedge clk);
      p_alloc = 60; p_flush = 3; p_ready = 70;
      if (cyc >= 1500 && cyc < 2500) begin p_ready = 0; p_alloc = 90; p_flush = 0; end
      if (cyc >= 4000) p_flush = 8;
      e_full = (m_tail - m_head) == DEPTH;
      e_cmv = m_ret != m_head;
      a = ($urandom % 100) < p_alloc;
      rv = (m_ret < m_tail) && m_av[m_ret % RING] && ($urandom % 2 == 1);
      ex = 0; s = 0;
      if (m_tail > m_ret)
        for (int t = 0; t < 4; t++) begin
          int c;
          c = m_ret + int'($urandom % (m_tail - m_ret));
          if (!ex && !m_av[c % RING]) begin ex = 1; s = c; end
        end
      fl = ($urandom % 100) < p_flush;
      lo = m_ret + (rv ? 1 : 0);
      ft = lo + int'($urandom % (m_tail - lo + 1));
      age = m_head + int'($urandom % (m_tail - m_head + 1));
      alloc_req = a;
      ret_valid = rv;
      ex_valid = ex;
      ex_idx = IW'(s % DEPTH);
      ex_addr = ($urandom % 8) * 4;
      ex_data = $urandom;
      flush_valid = fl;
      flush_tail = PW'(ft % (2 * DEPTH));
      cm_ready = ($urandom % 100) < p_ready;
      ld_age = PW'(age % (2 * DEPTH));
      ld_addr = ($urandom % 8) * 4;
      #1;
      e_hit = 0; e_wait = 0; e_ld = '0;
      for (int q = m_head; q < age; q++) begin
        if (!m_av[q % RING]) e_wait = 1;
        else if (m_addr[q % RING] == ld_addr) begin e_hit = 1; e_ld = m_data[q % RING]; end
      end
      if (e_wait) e_hit = 0;
      chk("R1 full", full, e_full);
      chk(was_flush ? "R5 alloc_ptr after flush" : "R1 alloc_ptr", alloc_ptr, m_tail % (2 * DEPTH));
      chk("R3 cm_valid", cm_valid, e_cmv);
      if (e_cmv) begin
        chk("R4 cm_addr", cm_addr, m_addr[m_head % RING]);
        chk("R4 cm_data", cm_data, m_data[m_head % RING]);
      end
      chk("R7 ld_wait", ld_wait, e_wait);
      chk((e_hit || e_wait) ? "R6 ld_hit" : "R8 ld_hit", ld_hit, e_hit);
      if (e_hit) chk("R6 R2 ld_data", ld_data, e_ld);
      if (e_cmv && cm_ready) m_head++;
      if (rv) m_ret++;
      if (ex) begin
        m_av[s % RING] = 1;
        m_addr[s % RING] = ex_addr;
        m_data[s % RING] = ex_data;
      end
      was_flush = fl;
      if (fl) m_tail = ft;
      else if (a && !e_full) begin m_av[m_tail % RING] = 0; m_tail++; end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule